// File: doc/BRIEF.md
# Dispatch Group Formation Checker

This block sits beside an instruction scheduler and tracks how full the current superscalar dispatch group is. In each cycle the scheduler presents one decoded candidate: a unit class, plus flags for first-slot-only, group-filling (single), two-op (cracked), counter-register write, and branch through the counter register. The block answers at once, without a clock edge, with one of three verdicts: the candidate may join the group, it may not join (stall), or it may join only after a filler no-op. It combines its own slot-position rules with a no-op request from a separate address-overlap checker.

The scheduler commits a candidate with the issue strobe. It consumes an empty slot, for an idle cycle or an inserted no-op, with the advance strobe. The block keeps a slot counter and a flag that records a counter-register write within the current group. It reports every group closure on a pulse output, which the overlap checker uses to clear its own store history. The group size, the number of leading slots open to the condition unit, and the cracked-op fill limit are parameters.

Top module: `dispatch_group_checker`

## Requirements
- R1: After reset the slot count is 0, the counter-written flag is 0, and with an idle candidate (unit code 0) the verdict is 00 and group_end_o is 0.
- R2: Verdicts are encoded 00 = clear, 01 = stall, 10 = no-op needed. Any unit code 1 to 6 (every non-branch class) gets a stall when SLOTS-1 slots are used. A branch (unit code 7) never stalls on slot count alone.
- R3: A candidate flagged first-only or single gets a stall unless the slot count is 0.
- R4: A cracked candidate gets a stall when more than CRACK_MAX slots (default 2) are used. On issue it consumes two slots.
- R5: A condition-unit candidate (unit code 6) gets a stall when COND_SLOTS or more slots (default 2) are used.
- R6: Issuing a branch (unit code 7) or a single candidate closes the group in that cycle: group_end_o pulses and the slot count is 0 on the next cycle.
- R7: When an issue or advance brings the count to SLOTS or beyond, the group ends. group_end_o pulses, and on the next cycle the count and the counter-written flag are both 0.
- R8: Issuing a candidate with the counter-write flag set sets the counter-written flag. A branch-via-counter candidate that arrives while the flag is set, and has no slot stall, gets 10.
- R9: An advance strobe alone adds one slot to the count.
- R10: Unit code 0 is a pseudo candidate. It always gets verdict 00, and issuing it changes neither the slot count nor the flag.
- R11: The external overlap no-op input gives verdict 10 only when no slot rule has raised a stall. A stall takes precedence and gives 01.
- R12: Issue and advance in the same cycle apply the issue first. If the issue closes the group, the advance is dropped and adv_error_o is 1 in that cycle.
- R13: An issue strobe commits the candidate whatever verdict is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| unit_i | input | 3 | Candidate unit class: 0 pseudo, 1 integer, 2 memory, 3 float, 4 vector arithmetic, 5 vector permute, 6 condition, 7 branch |
| first_only_i | input | 1 | Candidate may only lead a group |
| single_i | input | 1 | Candidate fills a whole group |
| cracked_i | input | 1 | Candidate splits into two ops |
| ctr_write_i | input | 1 | Candidate writes the counter register |
| ctr_branch_i | input | 1 | Candidate branches through the counter register |
| overlap_noop_i | input | 1 | No-op request from the address-overlap checker |
| issue_i | input | 1 | Commit the presented candidate |
| advance_i | input | 1 | Consume one empty slot (idle cycle or inserted no-op) |
| verdict_o | output | 2 | 00 clear, 01 stall, 10 no-op needed |
| slots_used_o | output | $clog2(SLOTS) | Slots filled in the current group |
| ctr_written_o | output | 1 | Counter register written in the current group |
| group_end_o | output | 1 | The strobes of this cycle close the group |
| adv_error_o | output | 1 | Advance dropped because the issue in the same cycle closed the group |

## Verification
The bench builds the block with its defaults: SLOTS = 5, COND_SLOTS = 2, CRACK_MAX = 2. This small setting makes an exhaustive sweep possible. Every reachable slot count, with the counter-written flag both clear and set, is crossed with all eight unit codes, every first-only/single/cracked combination, and both no-op sources. The bench also issues every unit and flag combination from each slot count and checks the next count, the closure pulse and the flag. Advance-only wraps and same-cycle issue-plus-advance collisions are covered as well.

// File: rtl/dgc_pkg.sv
package dgc_pkg;

   typedef enum logic [2:0] {
      UC_PSEUDO = 3'd0,
      UC_INT    = 3'd1,
      UC_MEM    = 3'd2,
      UC_FLT    = 3'd3,
      UC_VARITH = 3'd4,
      UC_VPERM  = 3'd5,
      UC_COND   = 3'd6,
      UC_BRANCH = 3'd7
   } unit_e;

   typedef enum logic [1:0] {
      VD_CLEAR = 2'b00,
      VD_STALL = 2'b01,
      VD_NOOP  = 2'b10
   } verdict_e;

   localparam int NUM_UNITS = 8;

endpackage

// File: rtl/dgc_rules.sv
module dgc_rules
   import dgc_pkg::*;
#(
   parameter int SLOTS      = 5,
   parameter int COND_SLOTS = 2,
   parameter int CRACK_MAX  = 2,
   localparam int CNT_W     = $clog2(SLOTS)
) (
   input  unit_e            unit,
   input  logic             first_only,
   input  logic             single,
   input  logic             cracked,
   input  logic             ctr_branch,
   input  logic             overlap_noop,
   input  logic [CNT_W-1:0] count,
   input  logic             ctr_written,
   output logic             slot_stall,
   output verdict_e         verdict
);

   logic [NUM_UNITS-1:0] cls_ok;

   // One ceiling per unit class: the count must stay below it.
   for (genvar c = 0; c < NUM_UNITS; c++) begin : g_cap
      localparam int CAP = (c == int'(UC_BRANCH)) ? SLOTS :
                           (c == int'(UC_COND))   ? COND_SLOTS : SLOTS - 1;
      assign cls_ok[c] = (int'(count) < CAP);
   end

   always_comb begin
      slot_stall = 1'b0;
      if (unit != UC_PSEUDO) begin
         if ((first_only || single) && (count != '0))
            slot_stall = 1'b1;
         if (cracked && (int'(count) > CRACK_MAX))
            slot_stall = 1'b1;
         if (!cls_ok[unit])
            slot_stall = 1'b1;
      end
   end

   always_comb begin
      if (unit == UC_PSEUDO)
         verdict = VD_CLEAR;
      else if (slot_stall)
         verdict = VD_STALL;
      else if ((ctr_written && ctr_branch) || overlap_noop)
         verdict = VD_NOOP;
      else
         verdict = VD_CLEAR;
   end

endmodule

// File: rtl/dgc_slot_track.sv
module dgc_slot_track
   import dgc_pkg::*;
#(
   parameter int SLOTS   = 5,
   localparam int CNT_W  = $clog2(SLOTS),
   localparam int WIDE_W = $clog2(SLOTS + 2) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  unit_e            unit,
   input  logic             single,
   input  logic             cracked,
   input  logic             ctr_write,
   input  logic             issue,
   input  logic             advance,
   output logic [CNT_W-1:0] count,
   output logic             ctr_written,
   output logic             group_end,
   output logic             adv_error
);

   localparam logic [WIDE_W-1:0] FULL = WIDE_W'(SLOTS);
   localparam logic [WIDE_W-1:0] LAST = WIDE_W'(SLOTS - 1);

   logic               commit;
   logic [WIDE_W-1:0]  base, after_iss, mid, after_adv;
   logic               iss_end, adv_ok, adv_end, flag_mid;
   logic [CNT_W-1:0]   count_d;
   logic               flag_d;

   always_comb begin
      commit    = issue && (unit != UC_PSEUDO);
      base      = (unit == UC_BRANCH || single) ? LAST : WIDE_W'(count);
      after_iss = base + WIDE_W'(1) + WIDE_W'(cracked);
      iss_end   = commit && (after_iss >= FULL);
      mid       = !commit ? WIDE_W'(count) : (iss_end ? '0 : after_iss);
      flag_mid  = !iss_end && (ctr_written || (commit && ctr_write));
      adv_error = advance && iss_end;
      adv_ok    = advance && !iss_end;
      after_adv = mid + WIDE_W'(1);
      adv_end   = adv_ok && (after_adv >= FULL);
      group_end = iss_end || adv_end;
      if (adv_end)
         count_d = '0;
      else if (adv_ok)
         count_d = CNT_W'(after_adv);
      else
         count_d = CNT_W'(mid);
      flag_d = flag_mid && !adv_end;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count       <= '0;
         ctr_written <= 1'b0;
      end else begin
         count       <= count_d;
         ctr_written <= flag_d;
      end
   end

   // R6: branch or single issue closes the group
   p_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (unit == UC_BRANCH || (single && unit != UC_PSEUDO)))
      |=> (count == '0));

   // R7: a closed group leaves no counter-written flag behind
   p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      group_end |=> (!ctr_written && count == '0));

   // R7: stored count never reaches the group size
   p_count_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(count) < SLOTS));

   // R9: a lone advance adds exactly one slot
   p_adv_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !issue && (int'(count) < SLOTS - 1))
      |=> (int'(count) == int'($past(count)) + 1));

   // R10: pseudo issue leaves state untouched
   p_pseudo_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && unit == UC_PSEUDO && !advance)
      |=> ($stable(count) && $stable(ctr_written)));

endmodule

// File: rtl/dispatch_group_checker.sv
module dispatch_group_checker
   import dgc_pkg::*;
#(
   parameter int SLOTS      = 5,
   parameter int COND_SLOTS = 2,
   parameter int CRACK_MAX  = 2,
   localparam int CNT_W     = $clog2(SLOTS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [2:0]       unit_i,
   input  logic             first_only_i,
   input  logic             single_i,
   input  logic             cracked_i,
   input  logic             ctr_write_i,
   input  logic             ctr_branch_i,
   input  logic             overlap_noop_i,
   input  logic             issue_i,
   input  logic             advance_i,
   output logic [1:0]       verdict_o,
   output logic [CNT_W-1:0] slots_used_o,
   output logic             ctr_written_o,
   output logic             group_end_o,
   output logic             adv_error_o
);

   if (SLOTS < 3) begin : g_bad_slots
      $error("dispatch_group_checker: SLOTS must be at least 3");
   end
   if (COND_SLOTS < 1 || COND_SLOTS >= SLOTS) begin : g_bad_cond
      $error("dispatch_group_checker: COND_SLOTS out of range");
   end
   if (CRACK_MAX < 0 || CRACK_MAX > SLOTS - 3) begin : g_bad_crack
      $error("dispatch_group_checker: CRACK_MAX out of range");
   end

   unit_e    unit;
   verdict_e verdict;
   logic     slot_stall;

   assign unit      = unit_e'(unit_i);
   assign verdict_o = verdict;

   dgc_rules #(
      .SLOTS      (SLOTS),
      .COND_SLOTS (COND_SLOTS),
      .CRACK_MAX  (CRACK_MAX)
   ) u_rules (
      .unit         (unit),
      .first_only   (first_only_i),
      .single       (single_i),
      .cracked      (cracked_i),
      .ctr_branch   (ctr_branch_i),
      .overlap_noop (overlap_noop_i),
      .count        (slots_used_o),
      .ctr_written  (ctr_written_o),
      .slot_stall   (slot_stall),
      .verdict      (verdict)
   );

   dgc_slot_track #(
      .SLOTS (SLOTS)
   ) u_track (
      .clk         (clk_i),
      .rst_n       (rst_ni),
      .unit        (unit),
      .single      (single_i),
      .cracked     (cracked_i),
      .ctr_write   (ctr_write_i),
      .issue       (issue_i),
      .advance     (advance_i),
      .count       (slots_used_o),
      .ctr_written (ctr_written_o),
      .group_end   (group_end_o),
      .adv_error   (adv_error_o)
   );

   // R2: last slot is reserved for branches
   p_fifth_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unit_i != 3'd0 && unit_i != 3'd7 && int'(slots_used_o) == SLOTS - 1)
      |-> (verdict_o == 2'b01));

   // R3: first-only / single need an empty group
   p_first_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unit_i != 3'd0 && (first_only_i || single_i) && slots_used_o != '0)
      |-> (verdict_o == 2'b01));

   // R5: condition unit confined to leading slots
   p_cond_slots_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unit_i == 3'd6 && int'(slots_used_o) >= COND_SLOTS)
      |-> (verdict_o == 2'b01));

   // R8: counter-branch after a counter write asks for a no-op
   p_ctr_noop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unit_i != 3'd0 && ctr_written_o && ctr_branch_i && verdict_o != 2'b01)
      |-> (verdict_o == 2'b10));

   // R10: pseudo candidates are always clear
   p_pseudo_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unit_i == 3'd0) |-> (verdict_o == 2'b00));

   // R12: a dropped advance comes with the closure pulse
   p_adv_err_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adv_error_o |-> (group_end_o && issue_i && advance_i));

endmodule

// File: tb/tb_dispatch_group_checker.sv
`timescale 1ns/1ps
module tb_dispatch_group_checker;

   localparam int SLOTS = 5;
   localparam int COND  = 2;
   localparam int CRK   = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] unit = '0;
   logic       fo = 0, sg = 0, cr = 0, cw = 0, cb = 0, ovl = 0, iss = 0, adv = 0;
   logic [1:0] verdict;
   logic [2:0] slots;
   logic       ctrw, gend, aerr;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   dispatch_group_checker #(.SLOTS(SLOTS), .COND_SLOTS(COND), .CRACK_MAX(CRK)) dut (
      .clk_i(clk), .rst_ni(rst_n), .unit_i(unit), .first_only_i(fo), .single_i(sg),
      .cracked_i(cr), .ctr_write_i(cw), .ctr_branch_i(cb), .overlap_noop_i(ovl),
      .issue_i(iss), .advance_i(adv), .verdict_o(verdict), .slots_used_o(slots),
      .ctr_written_o(ctrw), .group_end_o(gend), .adv_error_o(aerr));

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic int model_verdict(int cnt, int cls, bit f, bit s, bit c, bit br, bit flag, bit ov);
      bit stall;
      if (cls == 0) return 0;
      stall = ((f || s) && cnt != 0) || (c && cnt > CRK) ||
              (cls != 7 && cls != 6 && cnt == SLOTS - 1) || (cls == 6 && cnt >= COND);
      if (stall) return 1;
      if ((br && flag) || ov) return 2;
      return 0;
   endfunction

   function automatic int model_next(int cnt, int cls, bit s, bit c);
      int n;
      if (cls == 0) return cnt;
      n = (cls == 7 || s) ? SLOTS - 1 : cnt;
      n = n + 1 + int'(c);
      return (n >= SLOTS) ? SLOTS : n;   // SLOTS marks a closure
   endfunction

   task automatic idle();
      unit = '0; fo = 0; sg = 0; cr = 0; cw = 0; cb = 0; ovl = 0; iss = 0; adv = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); idle(); rst_n = 0;
      @(negedge clk); @(negedge clk); rst_n = 1;
   endtask

   // reach a given count, optionally with the counter flag set (count >= 1)
   task automatic reach(int cnt, bit flag);
      int have;
      do_reset();
      have = 0;
      if (flag) begin
         unit = 3'd1; cw = 1; iss = 1;
         @(negedge clk); idle();
         have = 1;
      end
      while (have < cnt) begin
         adv = 1;
         @(negedge clk); adv = 0;
         have++;
      end
      check("R9 setup count", int'(slots), cnt);
      check("R8 setup flag", int'(ctrw), int'(flag));
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      do_reset();
      #1;
      check("R1 count", int'(slots), 0);
      check("R1 flag", int'(ctrw), 0);
      check("R1 verdict", int'(verdict), 0);
      check("R1 group_end", int'(gend), 0);

      // R2 R3 R4 R5 R8 R10 R11: exhaustive verdict sweep
      for (int fl = 0; fl < 2; fl++) begin
         for (int c0 = fl; c0 < SLOTS; c0++) begin
            reach(c0, bit'(fl));
            for (int cls = 0; cls < 8; cls++)
               for (int a = 0; a < 8; a++)
                  for (int b = 0; b < 4; b++) begin
                     @(negedge clk);
                     unit = 3'(cls); fo = a[0]; sg = a[1]; cr = a[2]; cb = b[0]; ovl = b[1];
                     #1;
                     check($sformatf("R2/R3/R4/R5/R8/R10/R11 verdict cnt=%0d cls=%0d a=%0d b=%0d fl=%0d",
                                     c0, cls, a, b, fl), int'(verdict),
                           model_verdict(c0, cls, a[0], a[1], a[2], b[0], bit'(fl), b[1]));
                  end
            @(negedge clk); idle();
         end
      end

      // R4 R6 R7 R8 R10 R13: issue sweep from every count
      for (int c0 = 0; c0 < SLOTS; c0++)
         for (int cls = 0; cls < 8; cls++)
            for (int a = 0; a < 8; a++) begin
               int nx;
               reach(c0, 1'b0);
               unit = 3'(cls); sg = a[0]; cr = a[1]; cw = a[2]; fo = 1'b1; iss = 1;
               nx = model_next(c0, cls, a[0], a[1]);
               #1;
               check($sformatf("R6/R7 group_end cnt=%0d cls=%0d a=%0d", c0, cls, a),
                     int'(gend), int'(nx == SLOTS));
               @(negedge clk); idle();
               check($sformatf("R4/R10/R13 next count cnt=%0d cls=%0d a=%0d", c0, cls, a),
                     int'(slots), (nx == SLOTS) ? 0 : nx);
               check($sformatf("R8/R7 flag cnt=%0d cls=%0d a=%0d", c0, cls, a),
                     int'(ctrw), int'(cls != 0 && a[2] && nx != SLOTS));
            end

      // R7 R9: advance-only wrap with the flag set
      reach(1, 1'b1);
      for (int k = 2; k <= SLOTS; k++) begin
         adv = 1; #1;
         check("R7 advance closure pulse", int'(gend), int'(k == SLOTS));
         @(negedge clk); adv = 0;
         check("R9 advance count", int'(slots), k % SLOTS);
         check("R7 flag after advance", int'(ctrw), int'(k != SLOTS));
      end

      // R12: issue closes group and advance in same cycle
      reach(2, 1'b0);
      unit = 3'd7; iss = 1; adv = 1; #1;
      check("R12 adv_error on collision", int'(aerr), 1);
      @(negedge clk); idle();
      check("R12 advance dropped", int'(slots), 0);
      reach(0, 1'b0);
      unit = 3'd1; iss = 1; adv = 1; #1;
      check("R12 no error when open", int'(aerr), 0);
      @(negedge clk); idle();
      check("R12 issue then advance", int'(slots), 2);
      reach(3, 1'b0);
      unit = 3'd2; cr = 1; iss = 1; adv = 1; #1;
      check("R12 cracked fills then advance", int'(aerr), 1);
      @(negedge clk); idle();
      check("R12 count after cracked fill", int'(slots), 0);

      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule